// File: doc/BRIEF.md
# Supply-Sequenced Fault and Restart Manager

This block decides, cycle by cycle, whether the switching stage of an off-line converter controller may deliver drive pulses. It takes digitized comparator flags on the supply rail, the bulk-sense input, temperature and feedback loading. From them it produces a run enable, a one-cycle soft-start request and the on/off command for the high-voltage startup current source. Each raw flag is synchronized and must read the same in two consecutive samples before the sequencer uses it.

In normal operation the startup source keeps the supply between the stop and start levels. Recoverable faults halt pulses, and pulses resume with a soft-start once the fault is gone. The recoverable faults are supply overvoltage, low bulk voltage, the external disable input and overtemperature. An overload on the feedback path that lasts a programmable number of clock cycles puts the block into protection. The same happens if the supply sags below its undervoltage level while the startup source is already charging it. In protection the source is instead paced between the latch-release level and the start level, and switching resumes only at the end of the second charge cycle. An external trip input latches the block off and keeps the supply cycling until the supply collapses below the power-on reset level. A three-bit code reports the dominant fault cause.

Top module: `supply_restart_ctrl`

## Requirements
- R1: After a synchronous reset, run_en is 0, soft_start is 0, hv_src_on is 1 and fault_code is 0.
- R2: From the off state, a stable start-level flag with no recoverable fault raises run_en, and soft_start is high for exactly one cycle as run_en rises.
- R3: A raw flag that is high for a single clock cycle changes none of the outputs.
- R4: Outside protection and latch, hv_src_on turns on when the supply falls below the stop level and turns off when it reaches the start level. Between those two levels it keeps its previous value.
- R5: A feedback overload held for OVL_CYCLES consecutive filtered cycles while running ends switching and reports fault_code 2. An overload that clears earlier restarts the count from zero.
- R6: In protection, the stop-level flag has no effect on hv_src_on. The source turns on only when the supply is below the latch-release level and turns off at the start level.
- R7: After protection, the first charge cycle (source on, then the start level reached) keeps run_en at 0. The second charge cycle restores run_en with one soft_start pulse.
- R8: Each recoverable fault stops switching, and its clearing restarts with one soft_start pulse. The codes are overvoltage 3, bulk low 4, external disable 5 and overtemperature 6.
- R9: The external trip input stops switching with fault_code 1. The block stays latched through any number of charge cycles and after the trip input is removed, and the source keeps cycling as in R6.
- R10: A supply below the power-on reset level clears the latch. The block returns to the off state with fault_code 0 and hv_src_on 1, and it starts again on the start level.
- R11: While running, the undervoltage flag enters protection (code 2) only when hv_src_on is already 1. With the source off, the flag has no effect.
- R12: fault_code priority is: latch (1), then protection (2), then overvoltage, bulk low, external disable and overtemperature in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_ge_start | input | 1 | Supply at or above the start level |
| sup_ge_stop | input | 1 | Supply at or above the stop level |
| sup_ge_rel | input | 1 | Supply at or above the latch-release level |
| sup_lt_por | input | 1 | Supply below the power-on reset level |
| sup_lt_uv | input | 1 | Supply below the undervoltage level |
| sup_ovp | input | 1 | Supply overvoltage |
| bulk_low | input | 1 | Bulk sense below the brown-out level |
| ext_off | input | 1 | External disable request |
| ext_trip | input | 1 | External permanent-latch request |
| over_temp | input | 1 | Die overtemperature |
| fb_overload | input | 1 | Feedback asks for maximum power |
| run_en | output | 1 | Switching permitted |
| soft_start | output | 1 | One-cycle soft-start request at each restart |
| hv_src_on | output | 1 | Startup current source on |
| fault_code | output | 3 | Dominant fault cause |

## Verification
A raw flag change lands in the filtered flags on the fourth rising edge after it. The registered outputs move on the fifth edge. The overload path settles on edge OVL_CYCLES+4. Most scenarios therefore wait six edges and sample at a falling edge. The overload test brackets the expiry exactly, checking run_en still high after OVL_CYCLES+3 edges and low one edge later. The soft_start pulse is counted over a ten-cycle window after each restart stimulus, so the count must be exactly one, whatever edge it lands on.

// File: rtl/fm_pkg.sv
package fm_pkg;

    typedef struct packed {
        logic ge_start;
        logic ge_stop;
        logic ge_rel;
        logic lt_por;
        logic lt_uv;
        logic ovp;
        logic bulk_low;
        logic ext_off;
        logic ext_trip;
        logic hot;
        logic fb_over;
    } cmp_t;

    localparam int NFLAG = $bits(cmp_t);

    typedef enum logic [2:0] {
        ST_OFF, ST_RUN, ST_HOLD, ST_PROT1, ST_PROT2, ST_LATCH
    } seq_st_t;

    typedef enum logic [2:0] {
        FC_NONE   = 3'd0,
        FC_LATCH  = 3'd1,
        FC_PROT   = 3'd2,
        FC_OVP    = 3'd3,
        FC_BULK   = 3'd4,
        FC_EXTOFF = 3'd5,
        FC_HOT    = 3'd6
    } fault_code_t;

    function automatic logic soft_fault(cmp_t f);
        return f.ovp | f.bulk_low | f.ext_off | f.hot;
    endfunction

    function automatic logic burst_mode(seq_st_t s);
        return (s == ST_PROT1) || (s == ST_PROT2) || (s == ST_LATCH);
    endfunction

    function automatic fault_code_t pick_code(seq_st_t s, cmp_t f);
        if (s == ST_LATCH)                        return FC_LATCH;
        if (s == ST_PROT1 || s == ST_PROT2)       return FC_PROT;
        if (f.ovp)                                return FC_OVP;
        if (f.bulk_low)                           return FC_BULK;
        if (f.ext_off)                            return FC_EXTOFF;
        if (f.hot)                                return FC_HOT;
        return FC_NONE;
    endfunction

endpackage

// File: rtl/fm_filter.sv
module fm_filter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] filt
);
    logic [W-1:0] s1, s2, s3;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                s1[i]   <= 1'b0;
                s2[i]   <= 1'b0;
                s3[i]   <= 1'b0;
                filt[i] <= 1'b0;
            end else begin
                s1[i] <= raw[i];
                s2[i] <= s1[i];
                s3[i] <= s2[i];
                if (s2[i] == s3[i]) filt[i] <= s2[i];
            end
        end

        // R3: disagreeing samples never move the filtered flag
        p_filter_hold_r3: assert property (@(posedge clk) disable iff (rst)
            (s2[i] != s3[i]) |=> $stable(filt[i]));
    end
endmodule

// File: rtl/fm_ovl_timer.sv
module fm_ovl_timer #(
    parameter int LIM = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic fb,
    output logic expired
);
    localparam int CW = $clog2(LIM + 1);
    localparam logic [CW-1:0] LAST = CW'(LIM - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en || !fb) cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    assign expired = en && fb && (cnt == LAST);

    // R5: a cleared overload restarts the count, so no expiry the next cycle
    p_timer_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (!fb) |=> !expired);
endmodule

// File: rtl/fm_seq.sv
module fm_seq
    import fm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cmp_t        f,
    input  logic        ovl_exp,
    output logic        tmr_en,
    output logic        run_en,
    output logic        ss_req,
    output logic        hv_on,
    output logic [2:0]  code
);
    seq_st_t st, nxt;
    logic    hv_n;
    logic    charged;

    assign charged = hv_on && f.ge_start;

    always_comb begin
        nxt = st;
        if (f.lt_por)        nxt = ST_OFF;
        else if (f.ext_trip) nxt = ST_LATCH;
        else begin
            unique case (st)
                ST_OFF:   if (f.ge_start && !soft_fault(f)) nxt = ST_RUN;
                ST_HOLD:  if (!soft_fault(f)) nxt = ST_RUN;
                ST_RUN: begin
                    if (ovl_exp || (f.lt_uv && hv_on)) nxt = ST_PROT1;
                    else if (soft_fault(f))            nxt = ST_HOLD;
                end
                ST_PROT1: if (charged) nxt = ST_PROT2;
                ST_PROT2: if (charged) nxt = soft_fault(f) ? ST_HOLD : ST_RUN;
                ST_LATCH: nxt = ST_LATCH;
                default:  nxt = ST_OFF;
            endcase
        end
    end

    always_comb begin
        hv_n = hv_on;
        if (f.lt_por)                                      hv_n = 1'b1;
        else if (f.ge_start)                               hv_n = 1'b0;
        else if (burst_mode(st) ? !f.ge_rel : !f.ge_stop)  hv_n = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_OFF;
            hv_on  <= 1'b1;
            ss_req <= 1'b0;
        end else begin
            st     <= nxt;
            hv_on  <= hv_n;
            ss_req <= (nxt == ST_RUN) && (st != ST_RUN);
        end
    end

    assign tmr_en = (st == ST_RUN);
    assign run_en = (st == ST_RUN);
    assign code   = pick_code(st, f);

    // R2: a soft-start request only accompanies running, and lasts one cycle
    p_ss_in_run_r2: assert property (@(posedge clk) disable iff (rst)
        ss_req |-> run_en);
    p_ss_single_r2: assert property (@(posedge clk) disable iff (rst)
        ss_req |=> !ss_req);
    // R4: reaching the start level always switches the source off
    p_hv_off_start_r4: assert property (@(posedge clk) disable iff (rst)
        (f.ge_start && !f.lt_por) |=> !hv_on);
    // R5: overload expiry while running enters protection
    p_ovl_prot_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && ovl_exp && !f.lt_por && !f.ext_trip) |=> (st == ST_PROT1));
    // R7: the first charge cycle never releases the output
    p_first_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PROT1) |=> (st != ST_RUN));
    // R9: the latch holds until the supply collapses
    p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LATCH && !f.lt_por) |=> (st == ST_LATCH));
    // R10: power-on reset level returns to off with source on
    p_por_release_r10: assert property (@(posedge clk) disable iff (rst)
        f.lt_por |=> (st == ST_OFF && hv_on));
endmodule

// File: rtl/supply_restart_ctrl.sv
module supply_restart_ctrl
    import fm_pkg::*;
#(
    parameter int OVL_CYCLES = 4_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sup_ge_start,
    input  logic       sup_ge_stop,
    input  logic       sup_ge_rel,
    input  logic       sup_lt_por,
    input  logic       sup_lt_uv,
    input  logic       sup_ovp,
    input  logic       bulk_low,
    input  logic       ext_off,
    input  logic       ext_trip,
    input  logic       over_temp,
    input  logic       fb_overload,
    output logic       run_en,
    output logic       soft_start,
    output logic       hv_src_on,
    output logic [2:0] fault_code
);
    cmp_t             raw_s;
    logic [NFLAG-1:0] filt_v;
    cmp_t             flt;
    logic             tmr_en;
    logic             ovl_exp;

    always_comb begin
        raw_s.ge_start = sup_ge_start;
        raw_s.ge_stop  = sup_ge_stop;
        raw_s.ge_rel   = sup_ge_rel;
        raw_s.lt_por   = sup_lt_por;
        raw_s.lt_uv    = sup_lt_uv;
        raw_s.ovp      = sup_ovp;
        raw_s.bulk_low = bulk_low;
        raw_s.ext_off  = ext_off;
        raw_s.ext_trip = ext_trip;
        raw_s.hot      = over_temp;
        raw_s.fb_over  = fb_overload;
    end

    fm_filter #(.W(NFLAG)) u_filter (
        .clk  (clk),
        .rst  (rst),
        .raw  (raw_s),
        .filt (filt_v)
    );

    assign flt = cmp_t'(filt_v);

    fm_ovl_timer #(.LIM(OVL_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en      (tmr_en),
        .fb      (flt.fb_over),
        .expired (ovl_exp)
    );

    fm_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .f       (flt),
        .ovl_exp (ovl_exp),
        .tmr_en  (tmr_en),
        .run_en  (run_en),
        .ss_req  (soft_start),
        .hv_on   (hv_src_on),
        .code    (fault_code)
    );
endmodule

// File: tb/test_supply_restart_ctrl.sv
module test_supply_restart_ctrl;
    localparam int OVL = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ge_start = 0, ge_stop = 0, ge_rel = 1, lt_por = 0, lt_uv = 1;
    logic ovp = 0, blow = 0, xoff = 0, xtrip = 0, hot = 0, fbo = 0;
    logic run_en, soft_start, hv_src_on;
    logic [2:0] fault_code;

    int checks = 0;
    int errors = 0;
    int ss_cnt;
    bit done = 0;

    always #10 clk = ~clk;

    supply_restart_ctrl #(.OVL_CYCLES(OVL)) i_supply_restart_ctrl (
        .clk(clk), .rst(rst),
        .sup_ge_start(ge_start), .sup_ge_stop(ge_stop), .sup_ge_rel(ge_rel),
        .sup_lt_por(lt_por), .sup_lt_uv(lt_uv), .sup_ovp(ovp),
        .bulk_low(blow), .ext_off(xoff), .ext_trip(xtrip),
        .over_temp(hot), .fb_overload(fbo),
        .run_en(run_en), .soft_start(soft_start),
        .hv_src_on(hv_src_on), .fault_code(fault_code)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic watch(input int n);
        ss_cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (soft_start) ss_cnt++;
        end
    endtask

    // one full burst charge cycle: drop below release level, then reach start
    task automatic charge_cycle();
        ge_start = 0; ge_stop = 0; ge_rel = 0;
        settle();
        ge_rel = 1; ge_stop = 1; ge_start = 1;
        watch(10);
        ge_start = 0;
        settle();
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(run_en == 0, "R1", "run_en", run_en, 0);
        chk(soft_start == 0, "R1", "soft_start", soft_start, 0);
        chk(hv_src_on == 1, "R1", "hv_src_on", hv_src_on, 1);
        chk(fault_code == 0, "R1", "fault_code", fault_code, 0);
    endtask

    task automatic t_startup();
        ge_stop = 1; lt_uv = 0;
        settle();
        chk(hv_src_on == 1, "R4", "hv between levels", hv_src_on, 1);
        chk(run_en == 0, "R2", "run before start", run_en, 0);
        ge_start = 1;
        watch(10);
        chk(run_en == 1, "R2", "run_en after start", run_en, 1);
        chk(ss_cnt == 1, "R2", "soft_start pulses", ss_cnt, 1);
        chk(hv_src_on == 0, "R4", "hv at start", hv_src_on, 0);
        ge_start = 0;
        settle();
        chk(hv_src_on == 0, "R4", "hv held off above stop", hv_src_on, 0);
        ge_stop = 0;
        settle();
        chk(hv_src_on == 1, "R4", "hv on below stop", hv_src_on, 1);
        chk(run_en == 1, "R4", "run while regulating", run_en, 1);
        ge_start = 1;
        settle();
        ge_start = 0; ge_stop = 1;
        settle();
        chk(hv_src_on == 0, "R4", "hv off after recharge", hv_src_on, 0);
    endtask

    task automatic t_glitch();
        xtrip = 1;
        @(negedge clk);
        xtrip = 0;
        settle();
        chk(run_en == 1 && fault_code == 0, "R3", "trip glitch run/code",
            fault_code, 0);
        hot = 1;
        @(negedge clk);
        hot = 0;
        settle();
        chk(run_en == 1 && fault_code == 0, "R3", "hot glitch run/code",
            fault_code, 0);
    endtask

    task automatic one_soft(input int which, input int code);
        case (which)
            0: ovp = 1;
            1: blow = 1;
            2: xoff = 1;
            default: hot = 1;
        endcase
        settle();
        chk(run_en == 0, "R8", "run stopped", run_en, 0);
        chk(fault_code == 3'(code), "R8", "fault code", fault_code, code);
        ovp = 0; blow = 0; xoff = 0; hot = 0;
        watch(10);
        chk(run_en == 1, "R8", "run resumed", run_en, 1);
        chk(ss_cnt == 1, "R8", "soft_start on resume", ss_cnt, 1);
    endtask

    task automatic t_recoverable();
        one_soft(0, 3);
        one_soft(1, 4);
        one_soft(2, 5);
        one_soft(3, 6);
        hot = 1; ovp = 1;
        settle();
        chk(fault_code == 3, "R12", "ovp over hot", fault_code, 3);
        ovp = 0;
        settle();
        chk(fault_code == 6, "R12", "hot alone", fault_code, 6);
        hot = 0;
        settle();
    endtask

    task automatic t_timer_reset();
        fbo = 1;
        repeat (OVL / 2) @(negedge clk);
        fbo = 0;
        settle();
        fbo = 1;
        repeat (OVL / 2) @(negedge clk);
        fbo = 0;
        settle();
        chk(run_en == 1, "R5", "interrupted overload no trip", run_en, 1);
        chk(fault_code == 0, "R5", "code after short overloads", fault_code, 0);
    endtask

    task automatic t_overload();
        fbo = 1;
        repeat (OVL + 3) @(posedge clk);
        @(negedge clk);
        chk(run_en == 1, "R5", "run before expiry", run_en, 1);
        @(negedge clk);
        chk(run_en == 0, "R5", "run after expiry", run_en, 0);
        chk(fault_code == 2, "R5", "protection code", fault_code, 2);
        fbo = 0;
        hot = 1;
        settle();
        chk(fault_code == 2, "R12", "protection over hot", fault_code, 2);
        hot = 0;
        ge_stop = 0;
        settle();
        chk(hv_src_on == 0, "R6", "stop level ignored", hv_src_on, 0);
        ge_rel = 0;
        settle();
        chk(hv_src_on == 1, "R6", "on below release", hv_src_on, 1);
        ge_rel = 1; ge_stop = 1; ge_start = 1;
        watch(10);
        chk(hv_src_on == 0, "R6", "off at start", hv_src_on, 0);
        chk(run_en == 0, "R7", "first cycle stays off", run_en, 0);
        chk(ss_cnt == 0, "R7", "no soft_start first cycle", ss_cnt, 0);
        ge_start = 0;
        settle();
        charge_cycle();
        chk(run_en == 1, "R7", "second cycle restarts", run_en, 1);
        chk(ss_cnt == 1, "R7", "soft_start second cycle", ss_cnt, 1);
    endtask

    task automatic t_uvp();
        lt_uv = 1;
        settle();
        chk(run_en == 1, "R11", "uv ignored with source off", run_en, 1);
        ge_stop = 0;
        settle();
        chk(run_en == 0, "R11", "uv with source on stops", run_en, 0);
        chk(fault_code == 2, "R11", "uv protection code", fault_code, 2);
        lt_uv = 0;
        charge_cycle();
        charge_cycle();
        chk(run_en == 1, "R11", "restart after uv protection", run_en, 1);
    endtask

    task automatic t_latch();
        xtrip = 1; blow = 1;
        settle();
        chk(run_en == 0, "R9", "trip stops", run_en, 0);
        chk(fault_code == 1, "R12", "latch over bulk low", fault_code, 1);
        blow = 0; xtrip = 0;
        charge_cycle();
        chk(hv_src_on == 0, "R9", "source cycles off at start", hv_src_on, 0);
        charge_cycle();
        charge_cycle();
        chk(run_en == 0, "R9", "latched after cycles", run_en, 0);
        chk(fault_code == 1, "R9", "latch code held", fault_code, 1);
        ge_rel = 0; ge_stop = 0;
        settle();
        chk(hv_src_on == 1, "R9", "source on below release", hv_src_on, 1);
        lt_por = 1;
        settle();
        chk(fault_code == 0, "R10", "code after por", fault_code, 0);
        chk(hv_src_on == 1, "R10", "source on after por", hv_src_on, 1);
        lt_por = 0; ge_rel = 1; ge_stop = 1;
        settle();
        chk(run_en == 0, "R10", "off until start", run_en, 0);
        ge_start = 1;
        watch(10);
        chk(run_en == 1, "R10", "restart after release", run_en, 1);
        chk(ss_cnt == 1, "R10", "soft_start after release", ss_cnt, 1);
        ge_start = 0;
        settle();
    endtask

    initial begin
        t_reset();
        t_startup();
        t_glitch();
        t_recoverable();
        t_timer_reset();
        t_overload();
        t_uvp();
        t_latch();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule